// File: doc/BRIEF.md
# DSD Silence-Pattern Auto-Mute Detector

This block watches a one-bit DSD stream. One copy sits on each channel. It looks for the standard 8-bit DSD silence byte, `8'b0110_1001`, repeated back to back. It samples one data bit on every rising edge of the DSD bit clock and slides an 8-bit window over the most recent bits.

When the window first holds the silence byte, the block locks to that byte alignment. From then on it compares each incoming bit with the bit expected at that position of the pattern. Each byte that completes without an error adds one to a saturating repetition counter. After a configurable number of consecutive copies (256 by default), the `mute` output goes high.

A single bit that differs from the expected one clears the counter, drops `mute` and sends the detector back to searching. An enable input lets software switch the function off; while it is low the detector holds no progress and never mutes. Using `mute` to silence the analog path is left to the logic downstream.

Top module: `dsd_mute_detect`

## Requirements
- R1: While `rst_n` is low, `mute` is low and all detection progress is discarded. This holds at once on the falling edge of `rst_n` and independently of the clock.
- R2: The silence byte is `8'h69` sent most significant bit first, so the first bit received is bit 7. `mute` rises on the clock edge that takes in the last bit of the 256th consecutive aligned copy. It is still low after 255 copies.
- R3: Detection locks at whatever bit offset the first complete silence byte arrives. Copies are then counted every 8 bits from that alignment.
- R4: One received bit that differs from the expected pattern bit clears the repetition count. A following run is muted only after a full 256 fresh copies, however long the run before the error was.
- R5: While `mute` is high, a wrong bit drives `mute` low on the same clock edge that takes in that bit.
- R6: The repetition counter saturates at the threshold. An unbroken run of any length, including one beyond 512 copies, keeps `mute` high.
- R7: With `en` low, the count is cleared, `mute` goes low on the next edge, and pattern bits received meanwhile are not counted. After `en` returns high, 8 fresh bits must fill the window before a first copy is recognised.
- R8: Counting and `mute` change only on the rising edge of `dsd_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dsd_clk | input | 1 | DSD bit clock, rising edge samples data |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Auto-mute function enable |
| dsd_bit | input | 1 | One-bit DSD data |
| mute | output | 1 | High while the silence run threshold is met |

## Verification
Each result is registered, so it shows one clock edge after the bit that causes it. `mute` rises on the edge that takes in the last bit of the threshold copy, and falls on the edge of the wrong bit or of the first low-enable cycle. The bench drives every bit on the falling clock edge and samples `mute` on the next falling edge. That places each check exactly one rising edge after its stimulus. Thresholds are probed on both sides, at 255 and 256 copies, so an off-by-one count or a late update shows up directly.

// File: rtl/dsd_mute_detect.sv
module dsd_mute_detect #(
  parameter int unsigned         PAT_W   = 8,
  parameter logic [PAT_W-1:0]    PATTERN = 8'h69,
  parameter int unsigned         REPEATS = 256
) (
  input  logic dsd_clk,
  input  logic rst_n,
  input  logic en,
  input  logic dsd_bit,
  output logic mute
);
  localparam int unsigned CNT_W  = $clog2(REPEATS + 1);
  localparam int unsigned POS_W  = $clog2(PAT_W);
  localparam int unsigned SEEN_W = $clog2(PAT_W + 1);
  localparam logic [CNT_W-1:0]  CNT_MAX  = CNT_W'(REPEATS);
  localparam logic [POS_W-1:0]  POS_LAST = POS_W'(PAT_W - 1);
  localparam logic [SEEN_W-1:0] SEEN_MAX = SEEN_W'(PAT_W);

  logic [PAT_W-1:0]  win;
  logic [SEEN_W-1:0] seen;
  logic [POS_W-1:0]  pos;
  logic [CNT_W-1:0]  cnt;
  logic              locked;

  wire [PAT_W-1:0] win_next = {win[PAT_W-2:0], dsd_bit};
  wire             full     = (seen >= SEEN_MAX - 1'b1);
  wire             hit      = full && (win_next == PATTERN);
  wire             exp_bit  = PATTERN[POS_LAST - pos];
  wire             good_bit = locked && (dsd_bit == exp_bit);

  assign mute = (cnt == CNT_MAX);

  always_ff @(posedge dsd_clk or negedge rst_n) begin
    if (!rst_n) begin
      win    <= '0;
      seen   <= '0;
      pos    <= '0;
      cnt    <= '0;
      locked <= 1'b0;
    end else begin
      win <= win_next;
      if (!en) begin
        seen   <= '0;
        pos    <= '0;
        cnt    <= '0;
        locked <= 1'b0;
      end else begin
        if (seen != SEEN_MAX) seen <= seen + 1'b1;
        if (good_bit) begin
          pos <= (pos == POS_LAST) ? '0 : pos + 1'b1;
          if (pos == POS_LAST && cnt != CNT_MAX) cnt <= cnt + 1'b1;
        end else if (hit) begin
          locked <= 1'b1;
          pos    <= '0;
          cnt    <= CNT_W'(1);
        end else begin
          locked <= 1'b0;
          pos    <= '0;
          cnt    <= '0;
        end
      end
    end
  end

  // R5: a wrong bit while muted releases the mute at that edge
  a_r5_release_on_error: assert property (@(posedge dsd_clk) disable iff (!rst_n)
    (en && mute && dsd_bit != exp_bit) |=> !mute);

  // R7: enable low clears progress by the next edge
  a_r7_enable_clears: assert property (@(posedge dsd_clk) disable iff (!rst_n)
    !en |=> (cnt == '0 && !mute && !locked));

  // R6: a saturated count holds while the pattern keeps matching
  a_r6_saturate_hold: assert property (@(posedge dsd_clk) disable iff (!rst_n)
    (en && mute && dsd_bit == exp_bit) |=> mute);

  // R3: the count only ever steps by one, restarts, or holds
  a_r3_count_step: assert property (@(posedge dsd_clk) disable iff (!rst_n)
    1'b1 |=> (cnt <= CNT_W'(1) || cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

  // R4: a count above one never survives an error bit
  a_r4_error_restart: assert property (@(posedge dsd_clk) disable iff (!rst_n)
    (en && locked && dsd_bit != exp_bit) |=> (cnt <= CNT_W'(1)));

  // R6: the count never passes the threshold
  a_r6_no_overflow: assert property (@(posedge dsd_clk) disable iff (!rst_n)
    cnt <= CNT_MAX);
endmodule

// File: tb/dsd_mute_detect_tb.sv
module dsd_mute_detect_tb;
  localparam int unsigned CLK_PERIOD = 10;
  localparam logic [7:0]  PAT   = 8'h69;
  localparam logic [7:0]  BREAK = 8'hFF;
  localparam int unsigned NVEC  = 6;
  localparam int unsigned VEC_BYTES [NVEC] = '{1, 8, 255, 256, 300, 520};
  localparam bit          VEC_MUTE  [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};

  logic dsd_clk = 1'b0;
  logic rst_n   = 1'b0;
  logic en      = 1'b1;
  logic dsd_bit = 1'b0;
  logic mute;

  int checks = 0;
  int fails  = 0;

  dsd_mute_detect u_dut (
    .dsd_clk(dsd_clk),
    .rst_n  (rst_n),
    .en     (en),
    .dsd_bit(dsd_bit),
    .mute   (mute)
  );

  always #(CLK_PERIOD/2) dsd_clk = ~dsd_clk;

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: mute=%b expected %b", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    dsd_bit = b;
    @(posedge dsd_clk);
    @(negedge dsd_clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic send_pat(input int unsigned n);
    for (int k = 0; k < n; k++) send_byte(PAT);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge dsd_clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge dsd_clk);
    check(mute, 1'b0, "R1 reset state");
    rst_n = 1'b1;
    @(negedge dsd_clk);

    // R2, R6: table of run lengths after a break byte
    for (int v = 0; v < NVEC; v++) begin
      send_byte(BREAK);
      send_pat(VEC_BYTES[v]);
      check(mute, VEC_MUTE[v], $sformatf("R2/R6 run of %0d copies", VEC_BYTES[v]));
    end

    // R5: error bit drops mute on its own edge
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    check(mute, 1'b1, "R5 mute held before error");
    send_bit(1'b0);
    check(mute, 1'b0, "R5 mute released on error bit");

    // R3: arbitrary bit offset
    send_byte(BREAK);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    send_pat(255);
    check(mute, 1'b0, "R3 offset run 255 copies");
    send_pat(1);
    check(mute, 1'b1, "R3 offset run 256 copies");

    // R4: single bad bit restarts counting
    send_byte(BREAK);
    send_pat(200);
    send_byte(8'h68);
    send_pat(255);
    check(mute, 1'b0, "R4 count restarted after bad bit");
    send_pat(1);
    check(mute, 1'b1, "R4 mute after 256 fresh copies");

    // R7: enable low
    en = 1'b0;
    send_bit(PAT[7]);
    check(mute, 1'b0, "R7 mute low one edge after enable low");
    for (int i = 6; i >= 0; i--) send_bit(PAT[i]);
    send_pat(300);
    check(mute, 1'b0, "R7 pattern ignored while disabled");
    en = 1'b1;
    send_pat(255);
    check(mute, 1'b0, "R7 fresh count after enable 255");
    send_pat(1);
    check(mute, 1'b1, "R7 fresh count after enable 256");

    // R8: no change between clock edges
    #1;
    dsd_bit = 1'b1;
    #2;
    check(mute, 1'b1, "R8 mute stable between edges");

    // R1: asynchronous reset while muted
    rst_n = 1'b0;
    #1;
    check(mute, 1'b0, "R1 async reset clears mute");
    @(negedge dsd_clk);
    rst_n = 1'b1;
    @(negedge dsd_clk);
    send_pat(255);
    check(mute, 1'b0, "R1 progress discarded by reset");

    summary();
  end
endmodule